// File: doc/BRIEF.md
# Punctured Rate-1/2 Parallel Turbo Encoder

This block encodes 15-bit frames with two identical recursive systematic convolutional encoders that work in parallel. One encoder sees the frame in its natural order. The other sees the same frame after a row-column permutation. Data arrives one bit per cycle with a frame-start marker and is held in an internal buffer. Once the frame is complete, both encoders step together over the 15 positions, and the block emits one two-bit symbol per cycle: the data bit and one parity bit.

Puncturing keeps the natural-order encoder's parity on odd output positions and the permuted-order encoder's parity on even output positions. The overall rate is therefore 1/2. No tail bits are appended. Each encoder's state restarts from zero with every frame.

The block sits between a bit source and a modulator. It only needs the source to mark the first bit of each frame and to hold off while a frame is being emitted.

Top module: `turbo_enc_top`

## Requirements
- R1: During reset, and on every cycle where `out_valid` is 0, `out_sys` and `out_par` are both 0.
- R2: The block waits for a frame. While it waits, a bit with `in_valid`=1 and `in_start`=0 is discarded. A bit with `in_valid`=1 and `in_start`=1 becomes frame position 1.
- R3: After a start, each further cycle with `in_valid`=1 takes the next position, up to position 15. Cycles with `in_valid`=0 in between take no position.
- R4: Let E0 be the clock edge that takes position 15. `out_valid` is 1 for the 15 cycles after edges E1 to E15, and 0 again after E16.
- R5: At output position k (1..15, counted from the first valid cycle), `out_sys` equals the frame bit at position k.
- R6: Each encoder keeps state s1,s2, starting at 0,0 at every frame start. Its feedback is a = x^s1^s2 and its parity is a^s2. The next state is s1=a, s2=s1.
- R7: At odd output positions k (1,3,...,15), `out_par` is the parity produced by the natural-order encoder at its step k.
- R8: At even output positions k, `out_par` is the parity produced by the permuted-order encoder at its step k. Frame position p=5r+c+1 fills row r (0..2), column c (0..4). The permuted encoder reads column by column, top to bottom, so at its step k (k-1 = 3c+r) it takes position 5r+c+1.
- R9: A bit with `in_valid`=1 and `in_start`=1 that arrives while a frame is being collected discards the bits collected so far. It becomes position 1 of a new frame.
- R10: Any input, including a start, that arrives while the block is emitting has no effect. The symbols being emitted do not change, and no new frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input bit present this cycle |
| in_start | input | 1 | Marks the bit as the first of a frame |
| in_bit | input | 1 | Serial data bit |
| out_valid | output | 1 | Output symbol present this cycle |
| out_sys | output | 1 | Systematic (data) bit of the symbol |
| out_par | output | 1 | Punctured parity bit of the symbol |

## Verification
The assertions assume that reset is applied before the first edge that counts, and that `in_valid`, `in_start` and `in_bit` are always 0 or 1. They also assume that a frame source normally waits for the emission to finish. The stimulus changes the inputs only on the falling edge and holds them at known values from time zero. It breaks the wait-for-emission rule only in the directed test that checks inputs are ignored during emission. That test stops driving starts before the last emission edge, so no second frame is collected by accident.

// File: rtl/turbo_pkg.sv
// Shared types for the punctured turbo encoder.
// Assumes: used by turbo_enc_top and its submodules only.
package turbo_pkg;

    // Phases of the frame controller
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_EMIT = 2'd2
    } tenc_phase_e;

endpackage

// File: rtl/rsc_enc.sv
// Recursive systematic convolutional encoder, one step per enabled cycle.
// Feedback and feedforward taps are parameters (bit j = coefficient of D^j).
// Parity is combinational from the current state and input bit.
// Assumes: clr and en are not both needed in one cycle (clr wins).
module rsc_enc #(
    parameter int MEM = 2,
    parameter logic [MEM:0] FB_TAPS = 3'b111,
    parameter logic [MEM:0] FF_TAPS = 3'b101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic din,
    output logic parity
);

    logic [MEM-1:0] st_q;   // st_q[0] is the most recent delay stage
    logic           fb_bit;

    // Feedback and parity from taps
    always_comb begin
        fb_bit = din;
        for (int j = 1; j <= MEM; j++) begin
            fb_bit = fb_bit ^ (FB_TAPS[j] & st_q[j-1]);
        end
        parity = FF_TAPS[0] & fb_bit;
        for (int j = 1; j <= MEM; j++) begin
            parity = parity ^ (FF_TAPS[j] & st_q[j-1]);
        end
    end

    // Shift register update, cleared on reset and frame start
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st_q <= '0;
        end else if (en) begin
            st_q <= {st_q[MEM-2:0], fb_bit};
        end
    end

    AST_CLEAR_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q == '0)); // R6

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(st_q)); // R6

endmodule

// File: rtl/frame_buf.sv
// Frame storage of ROWS*COLS bits, written in natural order.
// Two read ports: natural address, and (row, col) of the grid that is
// filled row by row; the second port serves the permuted encoder.
// Assumes: row < ROWS and col < COLS whenever the read is used.
module frame_buf #(
    parameter int ROWS = 3,
    parameter int COLS = 5,
    parameter int AW   = 4,
    parameter int RW   = 2,
    parameter int CLW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [AW-1:0] nat_addr,
    input  logic [RW-1:0] rd_row,
    input  logic [CLW-1:0] rd_col,
    input  logic          rd_chk,
    output logic          nat_bit,
    output logic          perm_bit
);

    localparam int NBITS = ROWS * COLS;

    logic [NBITS-1:0] mem_q;
    logic [AW-1:0]    perm_addr;

    // Bit store, written one position per accepted input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_bit;
        end
    end

    // Read ports: natural order and row-major grid address
    always_comb begin
        perm_addr = AW'(rd_row) * AW'(COLS) + AW'(rd_col);
        nat_bit   = mem_q[nat_addr];
        perm_bit  = mem_q[perm_addr];
    end

    AST_PERM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_chk |-> (int'(rd_row) < ROWS && int'(rd_col) < COLS)); // R8

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < NBITS)); // R3

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem_q)); // R10

endmodule

// File: rtl/turbo_enc_top.sv
// Punctured rate-1/2 turbo encoder for ROWS*COLS-bit frames.
// Collects a serial frame, then runs two RSC encoders in lockstep:
// one over natural order, one over the column-wise read of the grid.
// Output position k (1-based) carries the data bit plus encoder A parity
// at odd k or encoder B parity at even k.
// Assumes: inputs during emission are ignored by design.
module turbo_enc_top
    import turbo_pkg::*;
#(
    parameter int ROWS = 3,
    parameter int COLS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_start,
    input  logic in_bit,
    output logic out_valid,
    output logic out_sys,
    output logic out_par
);

    localparam int NBITS = ROWS * COLS;
    localparam int AW    = $clog2(NBITS + 1);
    localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int CLW   = (COLS > 1) ? $clog2(COLS) : 1;
    localparam logic [AW-1:0]  LAST_POS = AW'(NBITS - 1);
    localparam logic [RW-1:0]  LAST_ROW = RW'(ROWS - 1);

    tenc_phase_e    phase_q;
    logic [AW-1:0]  ld_cnt_q;
    logic [AW-1:0]  em_cnt_q;
    logic [RW-1:0]  row_q;
    logic [CLW-1:0] col_q;

    logic           take_start;
    logic           buf_we;
    logic [AW-1:0]  buf_waddr;
    logic           nat_bit;
    logic           perm_bit;
    logic           emitting;
    logic           par_a;
    logic           par_b;

    // Input acceptance decode
    always_comb begin
        emitting   = (phase_q == PH_EMIT);
        take_start = in_valid && in_start && !emitting;
        buf_we     = in_valid && !emitting && (in_start || phase_q == PH_LOAD);
        buf_waddr  = in_start ? '0 : ld_cnt_q;
    end

    // Frame controller: collect, then emit NBITS symbols
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            ld_cnt_q <= '0;
            em_cnt_q <= '0;
            row_q    <= '0;
            col_q    <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (take_start) begin
                        ld_cnt_q <= AW'(1);
                        phase_q  <= PH_LOAD;
                    end
                end
                PH_LOAD: begin
                    if (in_valid) begin
                        if (in_start) begin
                            ld_cnt_q <= AW'(1);
                        end else if (ld_cnt_q == LAST_POS) begin
                            ld_cnt_q <= '0;
                            em_cnt_q <= '0;
                            row_q    <= '0;
                            col_q    <= '0;
                            phase_q  <= PH_EMIT;
                        end else begin
                            ld_cnt_q <= ld_cnt_q + AW'(1);
                        end
                    end
                end
                PH_EMIT: begin
                    if (em_cnt_q == LAST_POS) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        em_cnt_q <= em_cnt_q + AW'(1);
                        if (row_q == LAST_ROW) begin
                            row_q <= '0;
                            col_q <= col_q + CLW'(1);
                        end else begin
                            row_q <= row_q + RW'(1);
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    frame_buf #(
        .ROWS(ROWS), .COLS(COLS), .AW(AW), .RW(RW), .CLW(CLW)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (buf_we),
        .wr_addr  (buf_waddr),
        .wr_bit   (in_bit),
        .nat_addr (em_cnt_q),
        .rd_row   (row_q),
        .rd_col   (col_q),
        .rd_chk   (emitting),
        .nat_bit  (nat_bit),
        .perm_bit (perm_bit)
    );

    // Natural-order encoder
    rsc_enc #(.MEM(2), .FB_TAPS(3'b111), .FF_TAPS(3'b101)) u_enc_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (take_start),
        .en     (emitting),
        .din    (nat_bit),
        .parity (par_a)
    );

    // Permuted-order encoder
    rsc_enc #(.MEM(2), .FB_TAPS(3'b111), .FF_TAPS(3'b101)) u_enc_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (take_start),
        .en     (emitting),
        .din    (perm_bit),
        .parity (par_b)
    );

    // Output register with odd/even puncturing (em_cnt 0 is position 1)
    always_ff @(posedge clk) begin
        if (!rst_n || !emitting) begin
            out_valid <= 1'b0;
            out_sys   <= 1'b0;
            out_par   <= 1'b0;
        end else begin
            out_valid <= 1'b1;
            out_sys   <= nat_bit;
            out_par   <= em_cnt_q[0] ? par_b : par_a;
        end
    end

    AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_sys && !out_par)); // R1

    AST_VALID_FROM_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(phase_q == PH_EMIT)); // R4

    AST_EMIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (emitting && em_cnt_q == LAST_POS) |=> (phase_q == PH_IDLE)); // R4

    AST_LOAD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_LOAD) |-> (ld_cnt_q <= LAST_POS && ld_cnt_q != '0)); // R3

    AST_NO_START_IN_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        emitting |=> (phase_q != PH_LOAD)); // R10

endmodule

// File: tb/turbo_enc_top_tb.sv
module turbo_enc_top_tb;

    localparam int NB = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_start = 1'b0;
    logic in_bit = 1'b0;
    logic out_valid, out_sys, out_par;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    turbo_enc_top u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_bit(in_bit), .out_valid(out_valid), .out_sys(out_sys), .out_par(out_par)
    );

    localparam logic [NB-1:0] VEC [8] = '{
        15'h0000, 15'h7FFF, 15'h0001, 15'h4000,
        15'h5555, 15'h2AAA, 15'h1234, 15'h6F0B
    };

    // Bit i of the results is output position i+1
    function automatic void model(input logic [NB-1:0] d,
                                  output logic [NB-1:0] sys,
                                  output logic [NB-1:0] par);
        logic a1, a2, b1, b2, fa, fb, pa, pb, xb;
        int r, c;
        a1 = 0; a2 = 0; b1 = 0; b2 = 0;
        for (int k = 0; k < NB; k++) begin
            r = k % 3; c = k / 3;
            xb = d[r*5 + c];
            fa = d[k] ^ a1 ^ a2; pa = fa ^ a2; a2 = a1; a1 = fa;
            fb = xb ^ b1 ^ b2;   pb = fb ^ b2; b2 = b1; b1 = fb;
            sys[k] = d[k];
            par[k] = (k % 2 == 0) ? pa : pb;
        end
    endfunction

    task automatic chk(input bit ok, input string req, input logic [NB-1:0] act,
                       input logic [NB-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // mode 0: plain, 1: gaps while loading, 2: noise inputs during emission
    task automatic run_frame(input logic [NB-1:0] d, input int mode,
                             output logic [NB-1:0] gs, output logic [NB-1:0] gp,
                             output bit tim_ok);
        tim_ok = 1'b1;
        for (int i = 0; i < NB; i++) begin
            if (mode == 1 && (i % 4) == 2) begin
                @(negedge clk); in_valid = 0; in_start = 1; in_bit = ~d[i];
            end
            @(negedge clk);
            in_valid = 1; in_start = (i == 0); in_bit = d[i];
        end
        @(negedge clk);
        if (out_valid) tim_ok = 1'b0;
        in_valid = (mode == 2); in_start = (mode == 2); in_bit = 1'b1;
        for (int k = 0; k < NB; k++) begin
            @(negedge clk);
            if (!out_valid) tim_ok = 1'b0;
            gs[k] = out_sys; gp[k] = out_par;
            in_valid = (mode == 2 && k < 14);
            in_start = in_valid;
            in_bit = k[0];
        end
        @(negedge clk);
        if (out_valid) tim_ok = 1'b0;
    endtask

    task automatic check_frame(input logic [NB-1:0] d, input int mode, input string tag);
        logic [NB-1:0] gs, gp, es, ep;
        bit tim;
        model(d, es, ep);
        run_frame(d, mode, gs, gp, tim);
        chk(tim, {"R4 timing ", tag}, {14'd0, tim}, 15'd1);
        chk(gs == es, {"R5 sys ", tag}, gs, es);
        chk((gp & 15'h5555) == (ep & 15'h5555), {"R7 odd parity ", tag},
            gp & 15'h5555, ep & 15'h5555);
        chk((gp & 15'h2AAA) == (ep & 15'h2AAA), {"R8 even parity ", tag},
            gp & 15'h2AAA, ep & 15'h2AAA);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [NB-1:0] d;
        bit quiet;
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_sys && !out_par, "R1 during reset",
            {12'd0, out_valid, out_sys, out_par}, 15'd0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk(!out_valid && !out_sys && !out_par, "R1 after reset",
            {12'd0, out_valid, out_sys, out_par}, 15'd0);

        // Vector table
        for (int v = 0; v < 8; v++) check_frame(VEC[v], 0, $sformatf("vec%0d", v));

        // R6: back-to-back frames must each start from zero state
        check_frame(15'h7FFF, 0, "R6 state after all-ones");
        check_frame(15'h0000, 0, "R6 zero frame after all-ones");

        // R3: gaps while loading
        check_frame(15'h3C5A, 1, "R3 gaps");

        // R2: stray bits while waiting are discarded
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); in_valid = 1; in_start = 0; in_bit = 1;
        end
        @(negedge clk); in_valid = 0;
        quiet = 1'b1;
        repeat (20) begin @(negedge clk); if (out_valid) quiet = 1'b0; end
        chk(quiet, "R2 stray bits no output", {14'd0, ~quiet}, 15'd0);
        check_frame(15'h0F0F, 0, "R2 after stray");

        // R9: restart mid-load
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); in_valid = 1; in_start = (i == 0); in_bit = 1;
        end
        check_frame(15'h1111, 0, "R9 restart");

        // R10: inputs during emission ignored
        check_frame(15'h5A3C, 2, "R10 noise");
        quiet = 1'b1;
        repeat (25) begin @(negedge clk); if (out_valid) quiet = 1'b0; end
        chk(quiet, "R10 no frame from emit-time start", {14'd0, ~quiet}, 15'd0);

        // Random frames
        for (int t = 0; t < 20; t++) begin
            d = NB'($urandom);
            check_frame(d, t % 2, $sformatf("rand%0d", t));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule